// File: doc/BRIEF.md
# Length-Prefixed Decimal Register Value Parser

This block takes a byte stream, one byte for each cycle in which the strobe is high, and decodes one encoded register value from it. The value opens with a count byte telling how many mantissa bytes follow. Next comes a packed byte that carries two independent signs, one for the mantissa and one for the exponent, plus a 6-bit decimal exponent magnitude. The unsigned mantissa bytes come last, most significant byte first.

When the final mantissa byte has been taken, the block raises a done pulse for one cycle. In that cycle it presents the assembled mantissa, both sign flags and the exponent magnitude. It also presents a widened two's-complement mantissa and a two's-complement exponent. The value the stream represents is signed mantissa times ten to the signed exponent. Scaling by that power of ten is left to the consumer.

A count byte of zero, or a count above the supported maximum, sets a sticky error flag. An abort input drops a value that is partly received. Fields keep their last decoded contents until the next done pulse.

Top module: `meter_value_parser`

## Requirements
- R1: While reset is high and in the cycle after it is released, done_o and err_o are 0 and every decoded field output is 0.
- R2: A count byte N with 1 <= N <= 4 is followed by one packed sign/exponent byte and then N mantissa bytes. mant_o equals those N bytes joined with the first one most significant, zero-extended to 32 bits.
- R3: In the packed byte, bit 7 set gives mant_neg_o = 1, bit 6 set gives exp_neg_o = 1, and bits 5:0 appear on exp_mag_o.
- R4: done_o is high for exactly one cycle: the cycle after the clock edge that took the final mantissa byte. It is low at all other times.
- R5: mant_s_o is a 33-bit two's-complement value equal to -mant_o when mant_neg_o is 1 and to +mant_o otherwise. This includes mant_o = 0xFFFFFFFF.
- R6: exp_s_o is a 7-bit two's-complement value equal to -exp_mag_o when exp_neg_o is 1 and to +exp_mag_o otherwise.
- R7: A count byte of 0 or greater than 4 sets err_o. The parser consumes no further bytes for that value, and the next valid byte is again read as a count. err_o stays set until reset.
- R8: Asserting abort_i for one cycle discards a partly received value. No done pulse follows for that value, and the next valid byte is read as a count.
- R9: All decoded field outputs keep their values in every cycle in which done_o is low, including across errors and aborts.
- R10: Bytes are taken only in cycles with in_valid high. Idle cycles between any two bytes of a value do not change the result.
- R11: The count byte of the next value may be presented in the cycle right after the final mantissa byte of the previous value, and it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Drop the value in progress and wait for a count byte |
| in_valid | input | 1 | in_byte holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| done_o | output | 1 | One-cycle pulse: a value has been decoded |
| err_o | output | 1 | Sticky illegal-count flag |
| mant_o | output | 32 | Unsigned assembled mantissa |
| mant_neg_o | output | 1 | Mantissa sign flag |
| exp_neg_o | output | 1 | Exponent sign flag |
| exp_mag_o | output | 6 | Exponent magnitude |
| mant_s_o | output | 33 | Signed mantissa, two's complement |
| exp_s_o | output | 7 | Signed exponent, two's complement |

## Verification
The assertions check four things on every cycle: the done pulse is one cycle wide, the error flag is sticky, the fields hold while done is low, and no done follows an abort. They also check that the sign bits of the two widened outputs agree with the sign flags and the magnitudes. Only the bench scenarios can show that the right bytes land in the right fields. Those scenarios cover a sweep over every packed-byte value at every legal count, gaps between bytes, back-to-back values, and the behaviour after illegal counts and aborts.

// File: rtl/mvp_pkg.sv
package mvp_pkg;

    localparam int EXP_MAG_W = 6;
    localparam int EXP_S_W   = EXP_MAG_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SIGNEXP = 2'd1,
        ST_MANT    = 2'd2,
        ST_DONE    = 2'd3
    } pstate_t;

    typedef struct packed {
        logic                 mant_neg;
        logic                 exp_neg;
        logic [EXP_MAG_W-1:0] mag;
    } sexp_t;

    function automatic logic [EXP_S_W-1:0] signed_exp(input sexp_t s);
        logic [EXP_S_W-1:0] wide;
        wide = {1'b0, s.mag};
        return s.exp_neg ? (~wide + 1'b1) : wide;
    endfunction

endpackage

// File: rtl/mvp_framer.sv
module mvp_framer #(
    parameter int MAX_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 abort_i,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output mvp_pkg::pstate_t     state_o,
    output logic                 take_sexp_o,
    output logic                 take_mant_o,
    output logic                 last_mant_o,
    output logic                 err_o
);
    import mvp_pkg::*;

    localparam int         CNT_W   = $clog2(MAX_BYTES + 1);
    localparam logic [7:0] MAX_LEN = 8'(MAX_BYTES);

    pstate_t          state_q;
    logic [CNT_W-1:0] remain_q;
    logic             err_q;
    logic             len_ok;
    logic             want_len;

    assign len_ok   = (in_byte != 8'd0) && (in_byte <= MAX_LEN);
    assign want_len = (state_q == ST_IDLE) || (state_q == ST_DONE);

    assign take_sexp_o = in_valid && !abort_i && (state_q == ST_SIGNEXP);
    assign take_mant_o = in_valid && !abort_i && (state_q == ST_MANT);
    assign last_mant_o = take_mant_o && (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else if (abort_i) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    state_q <= ST_IDLE;
                    if (in_valid) begin
                        if (len_ok) begin
                            state_q  <= ST_SIGNEXP;
                            remain_q <= CNT_W'(in_byte);
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_SIGNEXP: begin
                    if (in_valid) state_q <= ST_MANT;
                end
                ST_MANT: begin
                    if (in_valid) begin
                        remain_q <= remain_q - CNT_W'(1);
                        if (remain_q == CNT_W'(1)) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign err_o   = err_q;

endmodule

// File: rtl/mvp_accum.sv
module mvp_accum #(
    parameter int MANT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic [7:0]        in_byte,
    output logic [MANT_W-1:0] acc_next_o
);
    logic [MANT_W-1:0] acc_q;

    assign acc_next_o = {acc_q[MANT_W-9:0], in_byte};

    always_ff @(posedge clk) begin
        if (rst || clear_i) acc_q <= '0;
        else if (shift_i)   acc_q <= acc_next_o;
    end

endmodule

// File: rtl/mvp_result.sv
module mvp_result #(
    parameter int MANT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            take_sexp_i,
    input  logic                            capture_i,
    input  logic [7:0]                      in_byte,
    input  logic [MANT_W-1:0]               mant_i,
    output logic [MANT_W-1:0]               mant_o,
    output mvp_pkg::sexp_t                  sexp_o,
    output logic [MANT_W:0]                 mant_s_o,
    output logic [mvp_pkg::EXP_S_W-1:0]     exp_s_o
);
    import mvp_pkg::*;

    sexp_t             stage_q;
    sexp_t             sexp_q;
    logic [MANT_W-1:0] mant_q;
    logic [MANT_W:0]   mant_s_q;
    logic [EXP_S_W-1:0] exp_s_q;
    logic [MANT_W:0]   wide;

    assign wide = {1'b0, mant_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            sexp_q   <= '0;
            mant_q   <= '0;
            mant_s_q <= '0;
            exp_s_q  <= '0;
        end else begin
            if (take_sexp_i) stage_q <= sexp_t'(in_byte);
            if (capture_i) begin
                sexp_q   <= stage_q;
                mant_q   <= mant_i;
                mant_s_q <= stage_q.mant_neg ? (~wide + 1'b1) : wide;
                exp_s_q  <= signed_exp(stage_q);
            end
        end
    end

    assign mant_o   = mant_q;
    assign sexp_o   = sexp_q;
    assign mant_s_o = mant_s_q;
    assign exp_s_o  = exp_s_q;

endmodule

// File: rtl/meter_value_parser.sv
module meter_value_parser #(
    parameter int MAX_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        abort_i,
    input  logic                        in_valid,
    input  logic [7:0]                  in_byte,
    output logic                        done_o,
    output logic                        err_o,
    output logic [8*MAX_BYTES-1:0]      mant_o,
    output logic                        mant_neg_o,
    output logic                        exp_neg_o,
    output logic [5:0]                  exp_mag_o,
    output logic [8*MAX_BYTES:0]        mant_s_o,
    output logic [6:0]                  exp_s_o
);
    import mvp_pkg::*;

    localparam int MANT_W = 8 * MAX_BYTES;

    pstate_t           state;
    logic              take_sexp;
    logic              take_mant;
    logic              last_mant;
    logic [MANT_W-1:0] acc_next;
    sexp_t             sexp;

    mvp_framer #(.MAX_BYTES(MAX_BYTES)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .abort_i     (abort_i),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .state_o     (state),
        .take_sexp_o (take_sexp),
        .take_mant_o (take_mant),
        .last_mant_o (last_mant),
        .err_o       (err_o)
    );

    mvp_accum #(.MANT_W(MANT_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (take_sexp || abort_i),
        .shift_i    (take_mant),
        .in_byte    (in_byte),
        .acc_next_o (acc_next)
    );

    mvp_result #(.MANT_W(MANT_W)) u_result (
        .clk         (clk),
        .rst         (rst),
        .take_sexp_i (take_sexp),
        .capture_i   (last_mant),
        .in_byte     (in_byte),
        .mant_i      (acc_next),
        .mant_o      (mant_o),
        .sexp_o      (sexp),
        .mant_s_o    (mant_s_o),
        .exp_s_o     (exp_s_o)
    );

    assign done_o     = (state == ST_DONE);
    assign mant_neg_o = sexp.mant_neg;
    assign exp_neg_o  = sexp.exp_neg;
    assign exp_mag_o  = sexp.mag;

endmodule

// File: rtl/mvp_checker.sv
module mvp_checker #(
    parameter int MANT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic              done_o,
    input logic              err_o,
    input logic [MANT_W-1:0] mant_o,
    input logic              mant_neg_o,
    input logic              exp_neg_o,
    input logic [5:0]        exp_mag_o,
    input logic [MANT_W:0]   mant_s_o,
    input logic [6:0]        exp_s_o
);
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_abort_no_done_r8: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !done_o);

    p_fields_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(mant_o) && $stable(mant_neg_o) && $stable(exp_neg_o)
                     && $stable(exp_mag_o) && $stable(mant_s_o) && $stable(exp_s_o)));

    p_mant_sign_r5: assert property (@(posedge clk) disable iff (rst)
        mant_s_o[MANT_W] == (mant_neg_o && (mant_o != '0)));

    p_exp_sign_r6: assert property (@(posedge clk) disable iff (rst)
        exp_s_o[6] == (exp_neg_o && (exp_mag_o != 6'd0)));

endmodule

bind meter_value_parser mvp_checker #(.MANT_W(8 * MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .abort_i    (abort_i),
    .done_o     (done_o),
    .err_o      (err_o),
    .mant_o     (mant_o),
    .mant_neg_o (mant_neg_o),
    .exp_neg_o  (exp_neg_o),
    .exp_mag_o  (exp_mag_o),
    .mant_s_o   (mant_s_o),
    .exp_s_o    (exp_s_o)
);

// File: tb/meter_value_parser_tb.sv
module meter_value_parser_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        abort_i = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        done_o;
    logic        err_o;
    logic [31:0] mant_o;
    logic        mant_neg_o;
    logic        exp_neg_o;
    logic [5:0]  exp_mag_o;
    logic [32:0] mant_s_o;
    logic [6:0]  exp_s_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    meter_value_parser u_dut (
        .clk(clk), .rst(rst), .abort_i(abort_i), .in_valid(in_valid), .in_byte(in_byte),
        .done_o(done_o), .err_o(err_o), .mant_o(mant_o), .mant_neg_o(mant_neg_o),
        .exp_neg_o(exp_neg_o), .exp_mag_o(exp_mag_o), .mant_s_o(mant_s_o), .exp_s_o(exp_s_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic send_value(input int len, input logic [7:0] se, input logic [31:0] m, input int gap);
        drive(8'(len));
        for (int g = 0; g < gap; g++) idle();
        drive(se);
        for (int i = len - 1; i >= 0; i--) begin
            for (int g = 0; g < gap; g++) idle();
            drive(m[8*i +: 8]);
        end
    endtask

    task automatic check_fields(input string tag, input logic [7:0] se, input logic [31:0] m);
        longint em;
        int     ee;
        em = se[7] ? -longint'(m) : longint'(m);
        ee = se[6] ? -int'(se[5:0]) : int'(se[5:0]);
        chk(done_o == 1'b1, {tag, " R4 done"}, done_o, 1);
        chk(mant_o == m, {tag, " R2 mant"}, mant_o, m);
        chk(mant_neg_o == se[7], {tag, " R3 mant_neg"}, mant_neg_o, se[7]);
        chk(exp_neg_o == se[6], {tag, " R3 exp_neg"}, exp_neg_o, se[6]);
        chk(exp_mag_o == se[5:0], {tag, " R3 exp_mag"}, exp_mag_o, se[5:0]);
        chk(longint'($signed(mant_s_o)) == em, {tag, " R5 mant_s"}, longint'($signed(mant_s_o)), em);
        chk(int'($signed(exp_s_o)) == ee, {tag, " R6 exp_s"}, int'($signed(exp_s_o)), ee);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        abort_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] m;
        logic [31:0] mask;
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(done_o == 0 && err_o == 0, "R1 flags", {done_o, err_o}, 0);
        chk(mant_o == 0 && mant_s_o == 0 && exp_s_o == 0 && exp_mag_o == 0 &&
            !mant_neg_o && !exp_neg_o, "R1 fields", mant_o, 0);

        // Spot values: 04 42 00 00 1B E4 ; 04 C2 00 00 30 39 ; 01 03 FF
        send_value(4, 8'h42, 32'h00001BE4, 0); idle(); check_fields("ex1", 8'h42, 32'd7140);
        send_value(4, 8'hC2, 32'h00003039, 0); idle(); check_fields("ex2", 8'hC2, 32'd12345);
        send_value(1, 8'h03, 32'h000000FF, 0); idle(); check_fields("ex3", 8'h03, 32'd255);
        // R5: full-width negative mantissa
        send_value(4, 8'hBF, 32'hFFFFFFFF, 0); idle(); check_fields("R5 max", 8'hBF, 32'hFFFFFFFF);
        // R4 + R9: next cycle done low, fields held
        idle();
        chk(done_o == 0, "R4 pulse width", done_o, 0);
        chk(mant_o == 32'hFFFFFFFF && exp_mag_o == 6'h3F, "R9 hold", mant_o, 32'hFFFFFFFF);

        // Sweep: every packed byte at every legal count, some with gaps (R10)
        for (int len = 1; len <= 4; len++) begin
            mask = (len == 4) ? 32'hFFFFFFFF : ((32'd1 << (8*len)) - 1);
            for (int se = 0; se < 256; se++) begin
                m = (32'(se) * 32'd2654435 + 32'(len) * 32'd977 + 32'd12345) & mask;
                send_value(len, 8'(se), m, (se % 5 == 0) ? 2 : 0);
                idle();
                check_fields((se % 5 == 0) ? "R10 gap" : "R2 sweep", 8'(se), m);
            end
        end

        // R11: back-to-back values
        send_value(2, 8'h45, 32'h0000ABCD, 0);
        drive(8'd3);
        check_fields("R11 first", 8'h45, 32'h0000ABCD);
        drive(8'h01);
        drive(8'h12); drive(8'h34); drive(8'h56);
        idle();
        check_fields("R11 second", 8'h01, 32'h00123456);

        // R7: illegal counts 0 and 5, sticky flag, no bytes consumed
        idle();
        chk(err_o == 0, "R7 clear before", err_o, 0);
        drive(8'd0); idle();
        chk(err_o == 1, "R7 zero count", err_o, 1);
        chk(done_o == 0 && mant_o == 32'h00123456, "R7 R9 fields held", mant_o, 32'h00123456);
        drive(8'd5);
        send_value(2, 8'h81, 32'h00000102, 0); idle();
        check_fields("R7 after bad", 8'h81, 32'h00000102);
        chk(err_o == 1, "R7 sticky", err_o, 1);
        drive(8'hFF);
        send_value(1, 8'h00, 32'h00000077, 0); idle();
        check_fields("R7 after FF", 8'h00, 32'h00000077);

        do_reset();
        @(negedge clk);
        chk(err_o == 0 && mant_o == 0, "R1 reset clears", err_o, 0);

        // R8: abort mid-value
        send_value(1, 8'h02, 32'h00000033, 0); idle(); check_fields("R8 pre", 8'h02, 32'h33);
        drive(8'd4); drive(8'h41); drive(8'hAA); drive(8'hBB);
        @(negedge clk);
        in_valid = 1'b0; abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(done_o == 0, "R8 no done", done_o, 0);
        chk(mant_o == 32'h33 && exp_mag_o == 6'd2, "R8 R9 held", mant_o, 32'h33);
        send_value(2, 8'h05, 32'h0000ABCD, 0); idle();
        check_fields("R8 after abort", 8'h05, 32'h0000ABCD);
        // abort with valid byte in same cycle: byte dropped
        drive(8'd2); drive(8'h00);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h99; abort_i = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; abort_i = 1'b0;
        send_value(1, 8'h07, 32'h00000011, 0); idle();
        check_fields("R8 drop", 8'h07, 32'h11);
        chk(err_o == 0, "R8 no error", err_o, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule